// File: doc/BRIEF.md
# Dual-Slot PCM Serial Data Interface

This block carries one voice sample per frame between parallel streams and a frame-synchronised serial line. The line has a bit clock, a frame-sync strobe, a receive data input and a transmit data output with its own output enable. The bit clock, the frame sync and the receive line are slow inputs. They are sampled by the fast system clock and their edges are found by comparing samples, so the whole block runs in one clock domain. Each frame holds two 8-bit or 16-bit slots plus a two-bit auxiliary gap. The position of the gap depends on the frame layout. Only the selected slot is driven and read.

Transmit samples arrive on a valid/ready stream. A one-word holding register sits behind it, and `s_tx_ready` is high exactly while that register is empty. The held word is taken when the selected slot begins. Received slot words leave on a second valid/ready stream. A word stays on `m_rx_data` with `m_rx_valid` high until the consumer raises `m_rx_ready`. A slot that completes while the previous word is still waiting is not delivered on the stream. In companded (8-bit) mode, two overrides exist. A control byte can be sent on the line in place of the held sample. A separately supplied byte can be delivered on the receive stream in place of the line data. A capture register always shows the last companded byte that was received.

Top module: `pcm_slot_if`

## Requirements
- R1: While reset is held and just after it, `tx_oe`, `tx_line` and `m_rx_valid` are 0, `s_tx_ready` is 1 and `rx_cap_byte` is 0.
- R2: When `align_mode`=00 (normal), a frame starts at a bit-clock rising edge where frame sync is high and was low at the previous rising edge. That edge is bit position 0. Transmit bits change after rising edges, MSB first, and receive bits are sampled at falling edges.
- R3: When `align_mode`=01 (reverse), frame detection and transmit launch use falling edges and receive sampling uses rising edges. The bit layout is otherwise as in R2.
- R4: When `align_mode`=10 or 11 (delayed), frame sync seen high at a falling edge, and low at the previous falling edge, arms the frame. Bit position 0 is launched at the next rising edge. Edge use is otherwise as in R2.
- R5: `tx_oe` is high only for launches inside the selected slot while `enable` is 1. It drops in the cycle after `enable` goes low. With `enable` at 0, no sample is taken from the holding register and nothing is received.
- R6: With slot width W, slot 1 starts at position 0. Slot 2 starts at W when `fmt2_sel`=0 (gap at 2W..2W+1), or at W+2 when `fmt2_sel`=1 (gap at W..W+1). `slot_b2_sel` picks slot 2.
- R7: When `linear_sel`=0, W=8. `s_tx_data[7:0]` is sent, and a received byte is delivered as `{8'h00, byte}`. When `linear_sel`=1, W=16. Bits 15..2 are sent and bits 1..0 go out as zero, and a received word is delivered with bits 1..0 cleared.
- R8: `s_tx_ready` is low while a word is held. A held word is used by exactly one slot. If no word is held when the slot starts, the slot carries all zeros.
- R9: `m_rx_valid` and `m_rx_data` stay unchanged until `m_rx_ready`. A word finished while one is pending is dropped from the stream, but `rx_cap_byte` still updates.
- R10: A pulse on `tx_ctl_wr` stores `tx_ctl_byte` as pending. In companded mode with `tx_ovr_en`=1 and a byte pending, the next slot sends that byte and clears the pending flag. The held sample is left in place for a later slot.
- R11: In companded mode, each received slot byte is written to `rx_cap_byte`. When `rx_ovr_en`=1, the word delivered on the stream is `{8'h00, rx_inj_byte}` instead of the line byte.
- R12: When `linear_sel`=1, both overrides have no effect: the held sample is sent and the line word is delivered.
- R13: A new frame-sync leading edge during a frame restarts at position 0, which aborts the current slot. A frame sync held high over many bits starts only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync strobe, leading edge marks a frame |
| rx_line | input | 1 | Serial receive data |
| tx_line | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable (line released when low) |
| align_mode | input | 2 | 00 normal, 01 reverse, 1x delayed |
| fmt2_sel | input | 1 | 1 places the two-bit gap between the slots |
| slot_b2_sel | input | 1 | 1 selects slot 2 |
| linear_sel | input | 1 | 1 selects 16-bit linear words |
| enable | input | 1 | Enables slot transfer |
| tx_ovr_en | input | 1 | Send pending control byte instead of sample |
| rx_ovr_en | input | 1 | Deliver injected byte instead of line byte |
| tx_ctl_wr | input | 1 | Store `tx_ctl_byte` as pending |
| tx_ctl_byte | input | 8 | Control byte for transmit override |
| rx_inj_byte | input | 8 | Byte delivered under receive override |
| s_tx_valid | input | 1 | Transmit sample valid |
| s_tx_ready | output | 1 | Holding register empty |
| s_tx_data | input | 16 | Transmit sample |
| m_rx_valid | output | 1 | Received word valid |
| m_rx_ready | input | 1 | Consumer accepts the received word |
| m_rx_data | output | 16 | Received word |
| rx_cap_byte | output | 8 | Last received companded byte |

## Verification
The assertions assume that `linear_sel` and the other mode inputs change only while no received word is waiting on the stream. They also assume that each bit-clock half period spans several system clocks. The bench meets both assumptions: it drains the receive stream before it reconfigures, and it holds every bit-clock level for four system clocks. It changes frame sync and receive data only together with a bit-clock edge, so every sampled value is settled.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic [1:0] {
    ALIGN_NORMAL    = 2'b00,
    ALIGN_REVERSE   = 2'b01,
    ALIGN_DELAYED   = 2'b10,
    ALIGN_DELAYED_B = 2'b11
  } align_e;

  typedef struct packed {
    align_e align;
    logic   fmt2;
    logic   slot_b2;
    logic   linear;
  } frame_cfg_t;
endpackage

// File: rtl/pcm_line_sync.sv
module pcm_line_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_slot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int GAP_W  = 2,
  parameter int POS_W  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  frame_cfg_t cfg,
  input  logic       bclk_lvl,
  input  logic       fs_lvl,
  output logic       launch,
  output logic       launch_in_slot,
  output logic       launch_first,
  output logic       rx_take,
  output logic       rx_last
);
  logic             bclk_prev, fs_prev, armed, active;
  logic [POS_W-1:0] pos, next_pos;
  logic [POS_W-1:0] w_len, s_off, s_end, f_last;
  logic             rise, fall, smp, det, det_start, start_now, cont;
  logic             reverse, delayed;

  assign rise = bclk_lvl & ~bclk_prev;
  assign fall = ~bclk_lvl & bclk_prev;

  assign reverse = (cfg.align == ALIGN_REVERSE);
  assign delayed = cfg.align[1];

  assign w_len  = cfg.linear ? POS_W'(WORD_W) : POS_W'(BYTE_W);
  assign s_off  = !cfg.slot_b2 ? '0 : (cfg.fmt2 ? w_len + POS_W'(GAP_W) : w_len);
  assign s_end  = s_off + w_len;
  assign f_last = w_len + w_len + POS_W'(GAP_W) - POS_W'(1);

  assign launch = reverse ? fall : rise;
  assign smp    = reverse ? rise : fall;
  assign det    = (cfg.align == ALIGN_NORMAL) ? rise : fall;

  assign det_start = det & fs_lvl & ~fs_prev;
  assign start_now = delayed ? (launch & armed) : det_start;
  assign cont      = active && (pos != f_last);
  assign next_pos  = start_now ? '0 : pos + POS_W'(1);

  assign launch_in_slot = launch && (start_now || cont) &&
                          (next_pos >= s_off) && (next_pos < s_end);
  assign launch_first   = (next_pos == s_off);

  assign rx_take = smp && active && (pos >= s_off) && (pos < s_end);
  assign rx_last = (pos == s_end - POS_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_prev <= 1'b0;
      fs_prev   <= 1'b0;
      armed     <= 1'b0;
      active    <= 1'b0;
      pos       <= '0;
    end else begin
      bclk_prev <= bclk_lvl;
      if (det) fs_prev <= fs_lvl;

      if (!delayed)                 armed <= 1'b0;
      else if (det_start)           armed <= 1'b1;
      else if (launch && armed)     armed <= 1'b0;

      if (launch) begin
        if (start_now) begin
          pos    <= '0;
          active <= 1'b1;
        end else if (cont) begin
          pos <= next_pos;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int ZERO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              linear,
  input  logic              ovr_en,
  input  logic              launch,
  input  logic              in_slot,
  input  logic              first,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_byte,
  output logic              tx_bit,
  output logic              tx_oe
);
  localparam logic [WORD_W-1:0] LSB_MASK = WORD_W'((1 << ZERO_W) - 1);

  logic              hold_v, pend;
  logic [WORD_W-1:0] hold_d, sh, load_word;
  logic [BYTE_W-1:0] ctl_q, comp_byte;
  logic              load, use_ovr, consume;

  assign s_ready   = ~hold_v;
  assign load      = en && launch && in_slot && first;
  assign use_ovr   = ~linear & ovr_en & pend;
  assign comp_byte = use_ovr ? ctl_q : (hold_v ? hold_d[BYTE_W-1:0] : '0);
  assign load_word = linear ? (hold_v ? (hold_d & ~LSB_MASK) : '0)
                            : {comp_byte, {(WORD_W-BYTE_W){1'b0}}};
  assign consume   = load && !use_ovr && hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (consume) begin
      hold_v <= 1'b0;
    end else if (s_valid && !hold_v) begin
      hold_v <= 1'b1;
      hold_d <= s_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ctl_q <= '0;
    end else if (ctl_wr) begin
      pend  <= 1'b1;
      ctl_q <= ctl_byte;
    end else if (load && use_ovr) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_oe  <= 1'b0;
      tx_bit <= 1'b0;
      sh     <= '0;
    end else if (!en) begin
      tx_oe <= 1'b0;
    end else if (launch) begin
      tx_oe <= in_slot;
      if (in_slot) begin
        if (first) begin
          tx_bit <= load_word[WORD_W-1];
          sh     <= {load_word[WORD_W-2:0], 1'b0};
        end else begin
          tx_bit <= sh[WORD_W-1];
          sh     <= {sh[WORD_W-2:0], 1'b0};
        end
      end else begin
        tx_bit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int ZERO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              linear,
  input  logic              ovr_en,
  input  logic              take,
  input  logic              last,
  input  logic              rx_lvl,
  input  logic [BYTE_W-1:0] inj_byte,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic [BYTE_W-1:0] cap_byte
);
  localparam logic [WORD_W-1:0] LSB_MASK = WORD_W'((1 << ZERO_W) - 1);

  logic [WORD_W-1:0] sh, sh_next, line_word, out_word;
  logic              shift, done;

  assign shift     = en && take;
  assign done      = shift && last;
  assign sh_next   = {sh[WORD_W-2:0], rx_lvl};
  assign line_word = linear ? (sh_next & ~LSB_MASK)
                            : {{(WORD_W-BYTE_W){1'b0}}, sh_next[BYTE_W-1:0]};
  assign out_word  = (!linear && ovr_en) ? {{(WORD_W-BYTE_W){1'b0}}, inj_byte}
                                         : line_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cap_byte <= '0;
    end else if (shift) begin
      sh <= sh_next;
      if (last && !linear) cap_byte <= sh_next[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (done && (!m_valid || m_ready)) begin
      m_valid <= 1'b1;
      m_data  <= out_word;
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if
  import pcm_slot_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int WORD_W      = 16,
  parameter int GAP_W       = 2,
  parameter int ZERO_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              tx_oe,
  input  logic [1:0]        align_mode,
  input  logic              fmt2_sel,
  input  logic              slot_b2_sel,
  input  logic              linear_sel,
  input  logic              enable,
  input  logic              tx_ovr_en,
  input  logic              rx_ovr_en,
  input  logic              tx_ctl_wr,
  input  logic [BYTE_W-1:0] tx_ctl_byte,
  input  logic [BYTE_W-1:0] rx_inj_byte,
  input  logic              s_tx_valid,
  output logic              s_tx_ready,
  input  logic [WORD_W-1:0] s_tx_data,
  output logic              m_rx_valid,
  input  logic              m_rx_ready,
  output logic [WORD_W-1:0] m_rx_data,
  output logic [BYTE_W-1:0] rx_cap_byte
);
  localparam int POS_W = $clog2(2 * WORD_W + GAP_W + 1);

  frame_cfg_t cfg;
  logic [2:0] line_q;
  logic       launch_evt, in_slot, slot_first, rx_take, rx_last;

  assign cfg.align   = align_e'(align_mode);
  assign cfg.fmt2    = fmt2_sel;
  assign cfg.slot_b2 = slot_b2_sel;
  assign cfg.linear  = linear_sel;

  pcm_line_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({rx_line, fsync, bclk}), .q(line_q)
  );

  pcm_frame_timer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .GAP_W(GAP_W), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .bclk_lvl(line_q[0]), .fs_lvl(line_q[1]),
    .launch(launch_evt), .launch_in_slot(in_slot), .launch_first(slot_first),
    .rx_take(rx_take), .rx_last(rx_last)
  );

  pcm_tx_lane #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .ZERO_W(ZERO_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(enable), .linear(linear_sel), .ovr_en(tx_ovr_en),
    .launch(launch_evt), .in_slot(in_slot), .first(slot_first),
    .s_valid(s_tx_valid), .s_ready(s_tx_ready), .s_data(s_tx_data),
    .ctl_wr(tx_ctl_wr), .ctl_byte(tx_ctl_byte),
    .tx_bit(tx_line), .tx_oe(tx_oe)
  );

  pcm_rx_lane #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .ZERO_W(ZERO_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(enable), .linear(linear_sel), .ovr_en(rx_ovr_en),
    .take(rx_take), .last(rx_last), .rx_lvl(line_q[2]), .inj_byte(rx_inj_byte),
    .m_valid(m_rx_valid), .m_ready(m_rx_ready), .m_data(m_rx_data),
    .cap_byte(rx_cap_byte)
  );
endmodule

// File: rtl/pcm_slot_if_chk.sv
module pcm_slot_if_chk #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              linear_sel,
  input logic              tx_oe,
  input logic              tx_line,
  input logic              launch_evt,
  input logic              s_tx_valid,
  input logic              s_tx_ready,
  input logic              m_rx_valid,
  input logic              m_rx_ready,
  input logic [WORD_W-1:0] m_rx_data
);
  assert_oe_off_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_oe);

  assert_oe_rises_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(launch_evt));

  assert_line_moves_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(tx_line) |-> $past(launch_evt));

  assert_tx_accept_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tx_valid && s_tx_ready) |=> !s_tx_ready);

  assert_rx_held_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && !m_rx_ready) |=> (m_rx_valid && $stable(m_rx_data)));

  assert_rx_linear_lsb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && linear_sel) |-> (m_rx_data[1:0] == 2'b00));

  assert_rx_comp_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && !linear_sel) |-> (m_rx_data[WORD_W-1:BYTE_W] == '0));
endmodule

bind pcm_slot_if pcm_slot_if_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .linear_sel(linear_sel),
  .tx_oe(tx_oe), .tx_line(tx_line), .launch_evt(launch_evt),
  .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready),
  .m_rx_valid(m_rx_valid), .m_rx_ready(m_rx_ready), .m_rx_data(m_rx_data)
);

// File: tb/pcm_slot_if_bench.sv
module pcm_slot_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, rx_line = 1'b0;
  logic tx_line, tx_oe;
  logic [1:0] align_mode = 2'b00;
  logic fmt2_sel = 1'b0, slot_b2_sel = 1'b0, linear_sel = 1'b0, enable = 1'b1;
  logic tx_ovr_en = 1'b0, rx_ovr_en = 1'b0, tx_ctl_wr = 1'b0;
  logic [7:0] tx_ctl_byte = 8'h00, rx_inj_byte = 8'h00;
  logic s_tx_valid = 1'b0;
  logic s_tx_ready;
  logic [15:0] s_tx_data = 16'h0000;
  logic m_rx_valid;
  logic m_rx_ready = 1'b0;
  logic [15:0] m_rx_data;
  logic [7:0] rx_cap_byte;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] cap_bits;
  int          oe_cnt;
  int          first_rel;

  always #4 clk = ~clk;

  pcm_slot_if u_pcm_slot_if (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    while (!s_tx_ready) @(negedge clk);
    s_tx_valid = 1'b1;
    s_tx_data  = d;
    @(negedge clk);
    s_tx_valid = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] b);
    @(negedge clk);
    tx_ctl_wr   = 1'b1;
    tx_ctl_byte = b;
    @(negedge clk);
    tx_ctl_wr = 1'b0;
  endtask

  task automatic pop(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk({req, " rx valid"}, {31'd0, m_rx_valid}, 32'd1);
    chk({req, " rx data"}, {16'd0, m_rx_data}, {16'd0, exp});
    m_rx_ready = 1'b1;
    @(negedge clk);
    m_rx_ready = 1'b0;
  endtask

  function automatic int wlen();
    return linear_sel ? 16 : 8;
  endfunction

  function automatic int soff();
    if (!slot_b2_sel) return 0;
    return fmt2_sel ? wlen() + 2 : wlen();
  endfunction

  function automatic logic fs_at(input int p, input int p2, input bit longfs);
    if (longfs) return (p <= wlen());
    return (p == 0) || (p2 > 0 && p == p2);
  endfunction

  // One frame on the line. p2 > 0 inserts a second frame-sync edge at that bit.
  task automatic run_frame(input logic [15:0] line_word, input int p2, input bit longfs);
    logic launch_lvl;
    bit   dly;
    int   w, s, n;
    w = wlen();
    s = soff();
    launch_lvl = (align_mode != 2'b01);
    dly = align_mode[1];
    cap_bits = 32'd0;
    oe_cnt = 0;
    first_rel = -1;
    fsync = 1'b0;
    bclk = ~launch_lvl;
    half();
    for (int k = 0; k < 2; k++) begin
      bclk = launch_lvl; half();
      bclk = ~launch_lvl; half();
    end
    if (dly) begin
      bclk = 1'b1; half();
      bclk = 1'b0; fsync = 1'b1; half();
    end
    n = 2 * w + 3 + (p2 > 0 ? p2 : 0);
    for (int p = 0; p < n; p++) begin
      int rel;
      rel = (p2 > 0 && p >= p2) ? p - p2 : p;
      bclk = launch_lvl;
      if (!dly) fsync = fs_at(p, p2, longfs);
      if (rel >= s && rel < s + w) rx_line = line_word[w - 1 - (rel - s)];
      else rx_line = 1'b1;
      half();
      if (tx_oe) begin
        cap_bits = {cap_bits[30:0], tx_line};
        if (first_rel < 0) first_rel = rel;
        oe_cnt++;
      end
      bclk = ~launch_lvl;
      if (dly) fsync = fs_at(p + 1, p2, longfs);
      half();
    end
    fsync = 1'b0;
    rx_line = 1'b0;
    bclk = launch_lvl; half();
    bclk = ~launch_lvl; half();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 tx_oe", {31'd0, tx_oe}, 32'd0);
    chk("R1 tx_line", {31'd0, tx_line}, 32'd0);
    chk("R1 m_rx_valid", {31'd0, m_rx_valid}, 32'd0);
    chk("R1 s_tx_ready", {31'd0, s_tx_ready}, 32'd1);
    chk("R1 rx_cap_byte", {24'd0, rx_cap_byte}, 32'd0);
  endtask

  task automatic t_normal();
    align_mode = 2'b00;
    push(16'h00A5);
    chk("R8 ready low when held", {31'd0, s_tx_ready}, 32'd0);
    run_frame(16'h003C, 0, 1'b0);
    chk("R2 tx byte", cap_bits, 32'h000000A5);
    chk("R2 slot width", oe_cnt, 32'd8);
    chk("R2 slot start", first_rel, 32'd0);
    chk("R8 ready after slot", {31'd0, s_tx_ready}, 32'd1);
    chk("R11 capture", {24'd0, rx_cap_byte}, 32'h3C);
    pop("R7 companded rx", 16'h003C);
  endtask

  task automatic t_reverse();
    align_mode = 2'b01;
    push(16'h005A);
    run_frame(16'h00C3, 0, 1'b0);
    chk("R3 tx byte", cap_bits, 32'h0000005A);
    chk("R3 slot start", first_rel, 32'd0);
    pop("R3 rx", 16'h00C3);
    align_mode = 2'b00;
  endtask

  task automatic t_delayed();
    align_mode = 2'b10;
    push(16'h0081);
    run_frame(16'h007E, 0, 1'b0);
    chk("R4 tx byte", cap_bits, 32'h00000081);
    chk("R4 slot start", first_rel, 32'd0);
    chk("R4 slot width", oe_cnt, 32'd8);
    pop("R4 rx", 16'h007E);
    align_mode = 2'b00;
  endtask

  task automatic t_slots();
    slot_b2_sel = 1'b1; fmt2_sel = 1'b0;
    push(16'h0042);
    run_frame(16'h0099, 0, 1'b0);
    chk("R6 B2 format1 start", first_rel, 32'd8);
    chk("R6 B2 format1 tx", cap_bits, 32'h00000042);
    pop("R6 B2 format1 rx", 16'h0099);
    fmt2_sel = 1'b1;
    push(16'h0024);
    run_frame(16'h0066, 0, 1'b0);
    chk("R6 B2 format2 start", first_rel, 32'd10);
    chk("R6 B2 format2 tx", cap_bits, 32'h00000024);
    pop("R6 B2 format2 rx", 16'h0066);
  endtask

  task automatic t_linear();
    linear_sel = 1'b1; slot_b2_sel = 1'b1; fmt2_sel = 1'b1;
    push(16'hBEEF);
    run_frame(16'h1237, 0, 1'b0);
    chk("R7 linear start", first_rel, 32'd18);
    chk("R7 linear width", oe_cnt, 32'd16);
    chk("R7 linear tx", cap_bits, 32'h0000BEEC);
    pop("R7 linear rx", 16'h1234);
    linear_sel = 1'b0; slot_b2_sel = 1'b0; fmt2_sel = 1'b0;
  endtask

  task automatic t_empty();
    run_frame(16'h0055, 0, 1'b0);
    chk("R8 empty slot zeros", cap_bits, 32'h00000000);
    chk("R8 empty slot driven", oe_cnt, 32'd8);
    pop("R8 rx", 16'h0055);
  endtask

  task automatic t_disable();
    push(16'h0033);
    enable = 1'b0;
    run_frame(16'h00F0, 0, 1'b0);
    chk("R5 no drive disabled", oe_cnt, 32'd0);
    chk("R5 no rx disabled", {31'd0, m_rx_valid}, 32'd0);
    chk("R5 sample kept", {31'd0, s_tx_ready}, 32'd0);
    enable = 1'b1;
    run_frame(16'h000F, 0, 1'b0);
    chk("R5 sample after enable", cap_bits, 32'h00000033);
    pop("R5 rx after enable", 16'h000F);
  endtask

  task automatic t_txovr();
    tx_ovr_en = 1'b1;
    ctl_write(8'h96);
    push(16'h0011);
    run_frame(16'h0001, 0, 1'b0);
    chk("R10 override byte sent", cap_bits, 32'h00000096);
    chk("R10 sample left held", {31'd0, s_tx_ready}, 32'd0);
    pop("R10 rx", 16'h0001);
    run_frame(16'h0002, 0, 1'b0);
    chk("R10 pending cleared", cap_bits, 32'h00000011);
    pop("R10 rx 2", 16'h0002);
    tx_ovr_en = 1'b0;
  endtask

  task automatic t_rxovr();
    rx_ovr_en = 1'b1;
    rx_inj_byte = 8'h4D;
    run_frame(16'h00E2, 0, 1'b0);
    chk("R11 capture under override", {24'd0, rx_cap_byte}, 32'hE2);
    pop("R11 injected", 16'h004D);
    rx_ovr_en = 1'b0;
  endtask

  task automatic t_backpressure();
    run_frame(16'h0011, 0, 1'b0);
    run_frame(16'h0022, 0, 1'b0);
    chk("R9 capture updates", {24'd0, rx_cap_byte}, 32'h22);
    pop("R9 first word kept", 16'h0011);
    @(negedge clk);
    chk("R9 second word dropped", {31'd0, m_rx_valid}, 32'd0);
  endtask

  task automatic t_restart();
    push(16'h00F0);
    run_frame(16'h00B7, 4, 1'b0);
    chk("R13 restart oe count", oe_cnt, 32'd12);
    chk("R13 restart tx bits", cap_bits, 32'h00000F00);
    pop("R13 restart rx", 16'h00B7);
  endtask

  task automatic t_longfs();
    push(16'h00C9);
    run_frame(16'h0035, 0, 1'b1);
    chk("R13 long sync width", oe_cnt, 32'd8);
    chk("R13 long sync tx", cap_bits, 32'h000000C9);
    pop("R13 long sync rx", 16'h0035);
  endtask

  task automatic t_linovr();
    linear_sel = 1'b1; tx_ovr_en = 1'b1; rx_ovr_en = 1'b1;
    rx_inj_byte = 8'h77;
    ctl_write(8'h96);
    push(16'h8001);
    run_frame(16'hABCD, 0, 1'b0);
    chk("R12 linear ignores tx override", cap_bits, 32'h00008000);
    chk("R12 sample consumed", {31'd0, s_tx_ready}, 32'd1);
    pop("R12 linear ignores rx override", 16'hABCC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_reverse();
    t_delayed();
    t_slots();
    t_linear();
    t_empty();
    t_disable();
    t_txovr();
    t_rxovr();
    t_backpressure();
    t_restart();
    t_longfs();
    t_linovr();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule